// File: doc/BRIEF.md
# Prioritized Exception Selector

This block watches every exception source that can reach a processor core and, on each clock, picks the one that should be taken next. The sources fall into three groups. The first is three fixed-rank sources: reset, the non-maskable interrupt and hard fault. The second is seven system handlers. The third is a bank of external interrupt lines, some of which are reserved and can never fire. The block presents the winner's exception position number and its effective level. It also raises a take flag when that winner is urgent enough to preempt what the core is running now.

External lines take part only after software enables them through a write port. Each system handler and each external line has a 3-bit programmable priority. A grouping field divides that priority into a group part and a subpriority part. Only the group part decides preemption. The full priority, and then the position number, only rank the sources that are pending.

Levels appear on a single scale on both the core input and the level output. Reset is 0, the non-maskable interrupt is 1, hard fault is 2, and a programmable field value p is 3+p (3 to 10). Any value of 11 or more on the core input means nothing is active. The level output reads 15 when nothing is pending.

Top module: `excsel_top`

## Requirements
- R1: After a synchronous reset, exc_take is 0, exc_num is 0 and exc_level is 15. Every enable bit, priority field and the grouping field read back as 0.
- R2: Reset, NMI and hard fault outrank every programmable source. They report positions 1, 2, 3 and levels 0, 1, 2, in that order of precedence.
- R3: Word address 0 sets enable bits and word address 1 clears them. A 1 in a written bit acts on that line and a 0 leaves it unchanged. Both addresses read back the enable vector. A pending line that is not enabled is never selected.
- R4: External lines 11, 12, 13, 26, 27, 30 and 31 are reserved. Their requests are ignored and their enable bits and priority fields always read 0.
- R5: Priorities live at word addresses 2 to 5 for external lines, eight 3-bit fields per word, with line k in word 2+k/8 at bits 4*(k%8) upward. The seven system handlers are at word address 6, with handler j at bits 4*j upward. The selected source's level is 3 plus its field, and a lower field wins.
- R6: Among pending sources with the same level, the one with the lowest position number is selected.
- R7: System handler inputs 0 to 6 report positions 4, 5, 6, 11, 12, 14 and 15. External line k reports position 16+k.
- R8: Word address 7 bits [1:0] give the number of subpriority bits, from 0 to 3. The take flag is 1 only when the winner's group level is strictly below the core's group level. The group level of a programmable level is 3 plus the field with its subpriority bits cleared. Levels 0 to 2, and core values above 10, keep their value as their group level.
- R9: Within one group, the subpriority still orders pending sources but cannot cause preemption.
- R10: The outputs are registered. A change on a request or on the core level shows on the outputs after exactly one rising clock edge. With nothing pending the outputs return to their idle values.
- R11: While the core level is 1, nothing except reset is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request |
| req_nmi | input | 1 | Non-maskable interrupt request |
| req_hard | input | 1 | Hard fault request |
| sys_req | input | 7 | System handler requests |
| irq_req | input | 32 | External interrupt requests |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered read data for cfg_addr |
| core_level | input | 4 | Level the core is currently running at |
| exc_take | output | 1 | Winner should preempt the core |
| exc_num | output | 6 | Position number of the winner |
| exc_level | output | 4 | Full level of the winner |

## Verification
The bound assertions check several rules on every cycle. A taken exception is always more urgent than the core level of the cycle before. Nothing but reset is taken while the core runs at level 1. A reset request always wins on the next cycle. An idle input set always yields idle outputs. No reserved or unused position is ever reported, and reserved enable bits never read back as 1. The bench scenarios are needed for the rest: the exact level and number chosen for each source and field value, tie breaking among many equal sources, the effect of each grouping setting, subpriority ordering without preemption, and the set/clear semantics of the enable words.

// File: rtl/excsel_pkg.sv
package excsel_pkg;
  localparam int FIXED_N  = 3;   // reset, NMI, hard fault
  localparam int SYS_N    = 7;   // programmable system handlers
  localparam int IRQ_BASE = 16;  // position of external line 0

  typedef enum logic [1:0] {
    FX_RESET = 2'd0,
    FX_NMI   = 2'd1,
    FX_HARD  = 2'd2
  } fixed_e;

  // position number of system handler slot idx
  function automatic int sys_position(input int idx);
    case (idx)
      0: return 4;
      1: return 5;
      2: return 6;
      3: return 11;
      4: return 12;
      5: return 14;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/excsel_regs.sv
module excsel_regs #(
  parameter int N_IRQ = 32,
  parameter int PRIO_W = 3,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter logic [N_IRQ-1:0] RSVD_MASK = 32'hCC00_3800,
  localparam int SB_W = $clog2(PRIO_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [N_IRQ-1:0]  irq_en,
  output logic [PRIO_W-1:0] irq_prio [N_IRQ],
  output logic [PRIO_W-1:0] sys_prio [excsel_pkg::SYS_N],
  output logic [SB_W-1:0]   sub_bits
);
  localparam int FPW       = DW / 4;
  localparam int IRQ_WORDS = (N_IRQ + FPW - 1) / FPW;
  localparam int A_SET     = 0;
  localparam int A_CLR     = 1;
  localparam int A_IRQP    = 2;
  localparam int A_SYSP    = A_IRQP + IRQ_WORDS;
  localparam int A_GRP     = A_SYSP + 1;
  localparam logic [N_IRQ-1:0] LIVE = ~RSVD_MASK;

  logic [N_IRQ-1:0] en_q;
  logic [SB_W-1:0]  sb_q;
  logic [DW-1:0]    rd_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (we && addr == AW'(A_SET)) begin
      en_q <= (en_q | wdata[N_IRQ-1:0]) & LIVE;
    end else if (we && addr == AW'(A_CLR)) begin
      en_q <= en_q & ~wdata[N_IRQ-1:0];
    end
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq_prio
    if (RSVD_MASK[i]) begin : g_rsvd
      assign irq_prio[i] = '0;
    end else begin : g_live
      localparam int WA = A_IRQP + i / FPW;
      localparam int FB = (i % FPW) * 4;
      logic [PRIO_W-1:0] p_q;
      always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else if (we && addr == AW'(WA)) p_q <= wdata[FB +: PRIO_W];
      end
      assign irq_prio[i] = p_q;
    end
  end

  for (genvar j = 0; j < excsel_pkg::SYS_N; j++) begin : g_sys_prio
    logic [PRIO_W-1:0] p_q;
    always_ff @(posedge clk) begin
      if (rst) p_q <= '0;
      else if (we && addr == AW'(A_SYSP)) p_q <= wdata[j*4 +: PRIO_W];
    end
    assign sys_prio[j] = p_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sb_q <= '0;
    else if (we && addr == AW'(A_GRP)) begin
      if (wdata[SB_W-1:0] > SB_W'(PRIO_W)) sb_q <= SB_W'(PRIO_W);
      else sb_q <= wdata[SB_W-1:0];
    end
  end

  always_comb begin
    rd_c = '0;
    if (addr == AW'(A_SET) || addr == AW'(A_CLR)) rd_c[N_IRQ-1:0] = en_q;
    for (int i = 0; i < N_IRQ; i++) begin
      if (addr == AW'(A_IRQP + i / FPW)) rd_c[(i % FPW) * 4 +: PRIO_W] = irq_prio[i];
    end
    for (int j = 0; j < excsel_pkg::SYS_N; j++) begin
      if (addr == AW'(A_SYSP)) rd_c[j * 4 +: PRIO_W] = sys_prio[j];
    end
    if (addr == AW'(A_GRP)) rd_c[SB_W-1:0] = sb_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else rdata <= rd_c;
  end

  assign irq_en   = en_q;
  assign sub_bits = sb_q;
endmodule

// File: rtl/excsel_arb.sv
module excsel_arb #(
  parameter int N_IRQ = 32,
  parameter int PRIO_W = 3,
  localparam int SB_W = $clog2(PRIO_W + 1),
  localparam int RK_W = $clog2(excsel_pkg::FIXED_N + (1 << PRIO_W) + 1),
  localparam int POS_W = $clog2(excsel_pkg::IRQ_BASE + N_IRQ)
) (
  input  logic [excsel_pkg::FIXED_N-1:0] fixed_req,
  input  logic [excsel_pkg::SYS_N-1:0]   sys_req,
  input  logic [PRIO_W-1:0]              sys_prio [excsel_pkg::SYS_N],
  input  logic [N_IRQ-1:0]               irq_req,
  input  logic [N_IRQ-1:0]               irq_en,
  input  logic [PRIO_W-1:0]              irq_prio [N_IRQ],
  input  logic [SB_W-1:0]                sub_bits,
  input  logic [RK_W-1:0]                core_level,
  output logic                           win_valid,
  output logic [POS_W-1:0]               win_pos,
  output logic [RK_W-1:0]                win_rank,
  output logic                           win_take
);
  import excsel_pkg::*;

  localparam int NC     = FIXED_N + SYS_N + N_IRQ;
  localparam int MAX_RK = FIXED_N + (1 << PRIO_W) - 1;

  logic             cand_v   [NC];
  logic [RK_W-1:0]  cand_rk  [NC];
  logic [POS_W-1:0] cand_pos [NC];

  for (genvar f = 0; f < FIXED_N; f++) begin : g_fixed
    assign cand_v[f]   = fixed_req[f];
    assign cand_rk[f]  = RK_W'(f);
    assign cand_pos[f] = POS_W'(f + 1);
  end

  for (genvar j = 0; j < SYS_N; j++) begin : g_sys
    localparam int C = FIXED_N + j;
    assign cand_v[C]   = sys_req[j];
    assign cand_rk[C]  = RK_W'(FIXED_N) + RK_W'(sys_prio[j]);
    assign cand_pos[C] = POS_W'(sys_position(j));
  end

  for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
    localparam int C = FIXED_N + SYS_N + k;
    assign cand_v[C]   = irq_req[k] & irq_en[k];
    assign cand_rk[C]  = RK_W'(FIXED_N) + RK_W'(irq_prio[k]);
    assign cand_pos[C] = POS_W'(IRQ_BASE + k);
  end

  // candidates are in rising position order, so strict "<" keeps the
  // lowest position on a level tie
  always_comb begin
    win_valid = 1'b0;
    win_rank  = '1;
    win_pos   = '0;
    for (int c = 0; c < NC; c++) begin
      if (cand_v[c] && (!win_valid || cand_rk[c] < win_rank)) begin
        win_valid = 1'b1;
        win_rank  = cand_rk[c];
        win_pos   = cand_pos[c];
      end
    end
  end

  function automatic logic [RK_W-1:0] group_of(input logic [RK_W-1:0] rk,
                                               input logic [SB_W-1:0] sb);
    logic [RK_W-1:0] off;
    if (rk < RK_W'(FIXED_N) || rk > RK_W'(MAX_RK)) return rk;
    off = rk - RK_W'(FIXED_N);
    off = (off >> sb) << sb;
    return off + RK_W'(FIXED_N);
  endfunction

  assign win_take = win_valid &&
                    (group_of(win_rank, sub_bits) < group_of(core_level, sub_bits));
endmodule

// File: rtl/excsel_top.sv
module excsel_top #(
  parameter int N_IRQ = 32,
  parameter int PRIO_W = 3,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter logic [N_IRQ-1:0] RSVD_MASK = 32'hCC00_3800,
  localparam int RK_W = $clog2(excsel_pkg::FIXED_N + (1 << PRIO_W) + 1),
  localparam int POS_W = $clog2(excsel_pkg::IRQ_BASE + N_IRQ)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_reset,
  input  logic                         req_nmi,
  input  logic                         req_hard,
  input  logic [excsel_pkg::SYS_N-1:0] sys_req,
  input  logic [N_IRQ-1:0]             irq_req,
  input  logic                         cfg_we,
  input  logic [AW-1:0]                cfg_addr,
  input  logic [DW-1:0]                cfg_wdata,
  output logic [DW-1:0]                cfg_rdata,
  input  logic [RK_W-1:0]              core_level,
  output logic                         exc_take,
  output logic [POS_W-1:0]             exc_num,
  output logic [RK_W-1:0]              exc_level
);
  import excsel_pkg::*;

  localparam int SB_W = $clog2(PRIO_W + 1);

  logic [N_IRQ-1:0]  irq_en;
  logic [PRIO_W-1:0] irq_prio [N_IRQ];
  logic [PRIO_W-1:0] sys_prio [SYS_N];
  logic [SB_W-1:0]   sub_bits;
  logic [FIXED_N-1:0] fixed_req;
  logic              a_valid;
  logic [POS_W-1:0]  a_pos;
  logic [RK_W-1:0]   a_rank;
  logic              a_take;

  always_comb begin
    fixed_req = '0;
    fixed_req[FX_RESET] = req_reset;
    fixed_req[FX_NMI]   = req_nmi;
    fixed_req[FX_HARD]  = req_hard;
  end

  excsel_regs #(
    .N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .DW(DW), .AW(AW), .RSVD_MASK(RSVD_MASK)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .irq_en(irq_en), .irq_prio(irq_prio),
    .sys_prio(sys_prio), .sub_bits(sub_bits)
  );

  excsel_arb #(
    .N_IRQ(N_IRQ), .PRIO_W(PRIO_W)
  ) u_arb (
    .fixed_req(fixed_req), .sys_req(sys_req), .sys_prio(sys_prio),
    .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
    .sub_bits(sub_bits), .core_level(core_level),
    .win_valid(a_valid), .win_pos(a_pos), .win_rank(a_rank), .win_take(a_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_take  <= 1'b0;
      exc_num   <= '0;
      exc_level <= '1;
    end else begin
      exc_take  <= a_take;
      exc_num   <= a_valid ? a_pos : '0;
      exc_level <= a_valid ? a_rank : '1;
    end
  end
endmodule

// File: rtl/excsel_chk.sv
module excsel_chk #(
  parameter int N_IRQ = 32,
  parameter int PRIO_W = 3,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter logic [N_IRQ-1:0] RSVD_MASK = 32'hCC00_3800,
  localparam int RK_W = $clog2(excsel_pkg::FIXED_N + (1 << PRIO_W) + 1),
  localparam int POS_W = $clog2(excsel_pkg::IRQ_BASE + N_IRQ)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_reset,
  input logic                         req_nmi,
  input logic                         req_hard,
  input logic [excsel_pkg::SYS_N-1:0] sys_req,
  input logic [N_IRQ-1:0]             irq_req,
  input logic [AW-1:0]                cfg_addr,
  input logic [DW-1:0]                cfg_rdata,
  input logic [RK_W-1:0]              core_level,
  input logic                         exc_take,
  input logic [POS_W-1:0]             exc_num,
  input logic [RK_W-1:0]              exc_level
);
  localparam int IW     = $clog2(N_IRQ);
  localparam int MAX_RK = excsel_pkg::FIXED_N + (1 << PRIO_W) - 1;

  logic          past_ok;
  logic          any_req;
  logic [IW-1:0] line_idx;
  logic          num_is_line;
  logic          num_rsvd;
  logic          num_legal;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else past_ok <= 1'b1;
  end

  always_comb begin
    any_req     = req_reset | req_nmi | req_hard | (|sys_req) | (|irq_req);
    num_is_line = (int'(exc_num) >= excsel_pkg::IRQ_BASE) &&
                  (int'(exc_num) < excsel_pkg::IRQ_BASE + N_IRQ);
    line_idx    = IW'(int'(exc_num) - excsel_pkg::IRQ_BASE);
    num_rsvd    = num_is_line && RSVD_MASK[line_idx];
    num_legal   = num_is_line || (exc_num >= POS_W'(1) && exc_num <= POS_W'(6)) ||
                  exc_num == POS_W'(11) || exc_num == POS_W'(12) ||
                  exc_num == POS_W'(14) || exc_num == POS_W'(15);
  end

  // R8: a taken exception is more urgent than the core's level
  p_take_urgent_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok && exc_take |-> exc_level < $past(core_level));

  // R11: under NMI only reset is taken
  p_nmi_guard_r11: assert property (@(posedge clk) disable iff (rst)
    past_ok && exc_take && $past(core_level) == RK_W'(1) |-> exc_num == POS_W'(1));

  // R2: a reset request always wins
  p_reset_wins_r2: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(req_reset) |-> exc_num == POS_W'(1) && exc_level == '0);

  // R10: nothing pending gives idle outputs one edge later
  p_idle_outputs_r10: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(any_req) |-> !exc_take && exc_num == '0 && exc_level == '1);

  // R4: reserved lines never reported
  p_no_rsvd_win_r4: assert property (@(posedge clk) disable iff (rst)
    !num_rsvd);

  // R4: reserved enable bits read as zero
  p_rsvd_en_zero_r4: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(cfg_addr) == AW'(0) |-> (cfg_rdata[N_IRQ-1:0] & RSVD_MASK) == '0);

  // R7: a taken exception has a defined position
  p_legal_pos_r7: assert property (@(posedge clk) disable iff (rst)
    exc_take |-> num_legal);

  // R5: a taken level lies on the defined scale
  p_level_range_r5: assert property (@(posedge clk) disable iff (rst)
    exc_take |-> exc_level <= RK_W'(MAX_RK));
endmodule

bind excsel_top excsel_chk #(
  .N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .DW(DW), .AW(AW), .RSVD_MASK(RSVD_MASK)
) u_chk (
  .clk(clk), .rst(rst), .req_reset(req_reset), .req_nmi(req_nmi),
  .req_hard(req_hard), .sys_req(sys_req), .irq_req(irq_req),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .core_level(core_level),
  .exc_take(exc_take), .exc_num(exc_num), .exc_level(exc_level)
);

// File: tb/test_excsel_top.sv
`timescale 1ns/1ps
module test_excsel_top;
  localparam logic [31:0] RSVD = 32'hCC00_3800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_reset = 1'b0, req_nmi = 1'b0, req_hard = 1'b0;
  logic [6:0]  sys_req = '0;
  logic [31:0] irq_req = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  core_level = 4'd15;
  logic        exc_take;
  logic [5:0]  exc_num;
  logic [3:0]  exc_level;

  int n_cmp = 0;
  int n_bad = 0;
  int sys_pos [7] = '{4, 5, 6, 11, 12, 14, 15};

  always #5 clk = ~clk;

  excsel_top i_excsel_top (
    .clk(clk), .rst(rst), .req_reset(req_reset), .req_nmi(req_nmi),
    .req_hard(req_hard), .sys_req(sys_req), .irq_req(irq_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .core_level(core_level), .exc_take(exc_take),
    .exc_num(exc_num), .exc_level(exc_level)
  );

  function automatic int grp(input int rk, input int sb);
    if (rk < 3 || rk > 10) return rk;
    return 3 + (((rk - 3) >> sb) << sb);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 4'(a);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic outs(input string tag, input logic t, input int n, input int l);
    chk({tag, " take"}, 32'(exc_take), 32'(t));
    chk({tag, " num"}, 32'(exc_num), 32'(n));
    chk({tag, " level"}, 32'(exc_level), 32'(l));
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    outs("R1 reset", 1'b0, 0, 15);
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk("R1 readback", d, 32'h0);
    end

    // R4 reserved enables and priority fields
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R4 enable set", d, ~RSVD);
    wr(3, 32'hFFFF_FFFF);
    rd(3, d); chk("R4 prio rsvd fields", d, 32'h7700_0777);
    wr(6, 32'hFFFF_FFFF);
    rd(6, d); chk("R5 sys prio readback", d, 32'h0777_7777);
    wr(7, 32'hFFFF_FFFF);
    rd(7, d); chk("R8 group readback", d, 32'h3);

    // R3 clear semantics
    wr(1, 32'h0);
    rd(1, d); chk("R3 clear zero no effect", d, ~RSVD);
    wr(1, 32'h0000_00F0);
    rd(0, d); chk("R3 clear ones", d, ~RSVD & 32'hFFFF_FF0F);
    for (int a = 2; a < 8; a++) wr(a, 32'h0);

    // R3 disabled line ignored
    wr(1, 32'hFFFF_FFFF);
    irq_req = 32'h0000_0001;
    settle();
    outs("R3 disabled", 1'b0, 0, 15);
    wr(0, 32'h0000_0001);
    settle();
    outs("R3 enabled", 1'b1, 16, 3);
    irq_req = '0;

    // R5/R7/R4 sweep over every line and priority
    wr(0, 32'hFFFF_FFFF);
    for (int k = 0; k < 32; k++) begin
      if (RSVD[k]) begin
        irq_req = 32'h1 << k;
        settle();
        outs("R4 rsvd request", 1'b0, 0, 15);
      end else begin
        irq_req = 32'h1 << k;
        for (int p = 0; p < 8; p++) begin
          wr(2 + k / 8, 32'(p) << ((k % 8) * 4));
          settle();
          outs("R5 R7 line", 1'b1, 16 + k, 3 + p);
        end
        wr(2 + k / 8, 32'h0);
      end
    end
    irq_req = '0;

    // R7/R5 system handler sweep
    for (int j = 0; j < 7; j++) begin
      sys_req = 7'(1 << j);
      for (int p = 0; p < 8; p++) begin
        wr(6, 32'(p) << (j * 4));
        settle();
        outs("R7 R5 sys", 1'b1, sys_pos[j], 3 + p);
      end
    end
    wr(6, 32'h0);
    sys_req = '0;

    // R6 tie sweep, all levels equal
    for (int k = 0; k < 32; k++) begin
      if (!RSVD[k]) begin
        irq_req = 32'hFFFF_FFFF << k;
        settle();
        outs("R6 tie lines", 1'b1, 16 + k, 3);
      end
    end
    irq_req = 32'hFFFF_FFFF;
    sys_req = 7'h7F;
    settle();
    outs("R6 tie sys vs lines", 1'b1, 4, 3);
    sys_req = 7'h78;
    settle();
    outs("R6 tie sys upper", 1'b1, 11, 3);

    // R2 fixed precedence
    req_hard = 1'b1; req_nmi = 1'b1; req_reset = 1'b1;
    settle();
    outs("R2 reset", 1'b1, 1, 0);
    req_reset = 1'b0;
    settle();
    outs("R2 nmi", 1'b1, 2, 1);
    req_nmi = 1'b0;
    settle();
    outs("R2 hard", 1'b1, 3, 2);
    req_hard = 1'b0;
    sys_req = '0; irq_req = '0;

    // R5 lower field wins regardless of position
    wr(2, 32'h0000_0600);          // line 2 field 6
    wr(4, 32'h0002_0000);          // line 20 field 2
    irq_req = 32'h0010_0004;
    settle();
    outs("R5 urgency", 1'b1, 36, 5);
    wr(6, 32'h0100_0000);          // handler 6 field 1
    sys_req = 7'h40;
    settle();
    outs("R5 sys beats line", 1'b1, 15, 4);
    sys_req = '0; irq_req = '0;
    for (int a = 2; a < 7; a++) wr(a, 32'h0);

    // R8 preemption sweep over field, grouping and core level
    irq_req = 32'h1;
    for (int p = 0; p < 8; p++) begin
      wr(2, 32'(p));
      for (int sb = 0; sb < 4; sb++) begin
        wr(7, 32'(sb));
        settle();
        for (int a = 0; a < 16; a++) begin
          @(negedge clk);
          core_level = 4'(a);
          @(negedge clk);
          chk("R8 take", 32'(exc_take), 32'(grp(3 + p, sb) < grp(a, sb)));
          chk("R8 level", 32'(exc_level), 32'(3 + p));
        end
      end
    end
    core_level = 4'd15;
    irq_req = '0;

    // R9 subpriority orders but does not preempt
    wr(7, 32'd2);
    wr(2, 32'h0000_1000);          // line 3 field 1, line 5 field 0
    irq_req = 32'h0000_0028;
    core_level = 4'd5;
    settle();
    outs("R9 same group", 1'b0, 21, 3);
    core_level = 4'd7;
    settle();
    outs("R9 other group", 1'b1, 21, 3);
    wr(2, 32'h0010_0000);          // line 5 field 1, line 3 field 0
    settle();
    outs("R9 swap", 1'b1, 19, 3);
    irq_req = '0;
    wr(2, 32'h0); wr(7, 32'h0);

    // R11 nothing but reset under NMI
    core_level = 4'd1;
    req_hard = 1'b1; irq_req = 32'h1;
    settle();
    outs("R11 hard blocked", 1'b0, 3, 2);
    req_reset = 1'b1;
    settle();
    outs("R11 reset passes", 1'b1, 1, 0);
    req_reset = 1'b0; req_hard = 1'b0; irq_req = '0;
    core_level = 4'd15;
    settle();

    // R10 exact one-edge latency
    @(negedge clk);
    irq_req = 32'h0000_0002;
    #2;
    chk("R10 before edge", 32'(exc_take), 32'h0);
    @(negedge clk);
    outs("R10 after edge", 1'b1, 17, 3);
    irq_req = '0;
    @(negedge clk);
    outs("R10 idle return", 1'b0, 0, 15);

    report();
    $finish;
  end
endmodule